// File: doc/BRIEF.md
# Fractional Clock Divider Channel

One output channel of a multi-output clock generator. A 16-bit control word, written over a simple register bus, sets an integer divider and an optional rotation stage. From every parent-clock cycle the channel derives a single-cycle clock-enable pulse stream. With the integer divider alone, one pulse is issued every D parent cycles. When rotation is active, the channel periodically drops one divided period, which slows the rate by divt/(divt+1). In the other direction it inserts one extra pulse, which speeds the rate by divt/(divt-1). The rotation period divt is a selectable base multiplied by a pre-divide factor.

The control word can be rewritten in full. The clock-enable bit can also be updated on its own, and this leaves every other field untouched. The written word is read back at once. The active configuration is taken over only when the current divided period ends, or at once while the channel is idle, so a rewrite never cuts a period short. A status output shows whether the active configuration has the clock enabled.

Top module: `fcd_channel`

## Requirements
- R1: After reset the read-back word is 0, the pulse output is low and the running flag is low.
- R2: A full write stores wr_data[15:0] as the control word and ignores the upper bus bits, which read back as 0. Field layout: bits 7:0 divider D, bits 10:8 pre-divide P, bit 11 direction, bits 13:12 rotation select, bit 14 rotation enable, bit 15 clock enable.
- R3: With rotation off and the clock enabled, exactly one pulse is issued every D parent cycles.
- R4: A divider field of 0 behaves as D = 1, giving a pulse on every cycle.
- R5: With rotation enabled and direction 0, divt = base × (P+1), where select codes 1, 2 and 3 give bases 16, 8 and 4. After every divt pulses, one divided period passes without a pulse, so there are divt pulses per (divt+1)·D cycles.
- R6: With rotation enabled, direction 1 and D ≥ 2, one extra pulse is issued in each group of divt−1 periods, so there are divt pulses per (divt−1)·D cycles.
- R7: Rotation enabled with select code 0 behaves as plain integer division.
- R8: Rotation enabled with direction 1 and an effective divider of 1 behaves as plain integer division.
- R9: While the active clock-enable bit is clear, no pulses are issued and the running flag is low.
- R10: An enable-only update changes bit 15 alone; every other field keeps its value.
- R11: When a full write and an enable-only update fall in the same cycle, the stored word takes bits 14:0 from the full write and bit 15 from the enable-only update.
- R12: A new configuration written while the channel is running takes effect at the end of the current divided period. That period keeps its full length, and the first new period starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full control-word write strobe |
| wr_data | input | BUS_W | Write data; bits 15:0 are used |
| en_wr | input | 1 | Enable-only update strobe |
| en_val | input | 1 | New clock-enable value for an enable-only update |
| rd_data | output | BUS_W | Stored control word, upper bits zero |
| clk_en_o | output | 1 | Output clock-enable pulse |
| running_o | output | 1 | Active configuration has the clock enabled |

## Verification
Two pairs of functions can coincide in one cycle. The first is a full control write landing together with an enable-only update. The bench drives both strobes on the same edge, in both polarities of the enable value, and judges the read-back word and the resulting pulse rate against the merge rule. The second is a rewrite landing in the middle of a running period. The bench issues a new divider three cycles after a pulse and measures the next two pulse gaps: the old period must complete at full length, and the new period must follow it directly.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int DIV_W  = 8;
  localparam int PRE_W  = 3;
  localparam int SEL_W  = 2;
  localparam int CTRL_W = 16;
  localparam int ROT_W  = 8;
  localparam int BASE_W = 5;

  // Field order is the bit layout of the control word (MSB first).
  typedef struct packed {
    logic             clk_on;
    logic             rot_on;
    logic [SEL_W-1:0] rsel;
    logic             fast;
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_DROP  = 2'd1,
    MODE_ADD   = 2'd2
  } rot_mode_e;

  function automatic logic [BASE_W-1:0] rot_base(input logic [SEL_W-1:0] s);
    case (s)
      2'd1:    rot_base = BASE_W'(16);
      2'd2:    rot_base = BASE_W'(8);
      2'd3:    rot_base = BASE_W'(4);
      default: rot_base = '0;
    endcase
  endfunction

endpackage

// File: rtl/fcd_ctrl_reg.sv
module fcd_ctrl_reg
  import fcd_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             at_bound,
  output logic [BUS_W-1:0] rd_data,
  output ctrl_t            act_o,
  output logic             load_o
);

  ctrl_t ctrl_q, ctrl_d;
  ctrl_t act_q, act_d;
  logic  pend_q, pend_d;
  logic  load;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (en_wr) ctrl_d.clk_on = en_val;
  end

  assign load   = pend_q && at_bound;
  assign pend_d = wr_en || en_wr || (pend_q && !load);
  assign act_d  = load ? ctrl_q : act_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  generate
    if (BUS_W > CTRL_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wr_data[BUS_W-1:CTRL_W];
      assign rd_data   = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
    end else begin : g_exact
      assign rd_data = ctrl_q;
    end
  endgenerate

  assign act_o  = act_q;
  assign load_o = load;

  AST_EN_ONLY_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_wr && !wr_en) |=> (ctrl_q[CTRL_W-2:0] == $past(ctrl_q[CTRL_W-2:0]))); // R10

  AST_MERGE_BIT15: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_wr && wr_en) |=> (ctrl_q.clk_on == $past(en_val))); // R11

endmodule

// File: rtl/fcd_rot_decode.sv
module fcd_rot_decode
  import fcd_pkg::*;
(
  input  ctrl_t            cfg,
  output logic [DIV_W-1:0] d_last,
  output logic [ROT_W-1:0] divt,
  output rot_mode_e        mode
);

  logic [ROT_W-1:0] base_w;
  logic [ROT_W-1:0] mult_w;
  logic             div_small;

  assign base_w    = ROT_W'(rot_base(cfg.rsel));
  assign mult_w    = ROT_W'(cfg.pre) + ROT_W'(1);
  assign divt      = base_w * mult_w;
  assign div_small = (cfg.div <= DIV_W'(1));
  assign d_last    = (cfg.div == '0) ? '0 : cfg.div - DIV_W'(1);

  always_comb begin
    mode = MODE_PLAIN;
    if (cfg.rot_on && (cfg.rsel != '0)) begin
      if (!cfg.fast)      mode = MODE_DROP;
      else if (!div_small) mode = MODE_ADD;
    end
  end

endmodule

// File: rtl/fcd_pulse_gen.sv
module fcd_pulse_gen
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] d_last,
  input  logic [ROT_W-1:0] divt,
  input  rot_mode_e        mode,
  output logic             pulse_o,
  output logic             at_bound
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [ROT_W-1:0] ph_q, ph_d;
  logic             pulse_q, pulse_d;
  logic             last, ph_wrap, drop_now, extra_now;

  assign last     = (cnt_q == d_last);
  assign at_bound = !run || last;

  always_comb begin
    case (mode)
      MODE_DROP: ph_wrap = (ph_q == divt);
      MODE_ADD:  ph_wrap = (ph_q == divt - ROT_W'(2));
      default:   ph_wrap = 1'b1;
    endcase
  end

  assign drop_now  = (mode == MODE_DROP) && ph_wrap;
  assign extra_now = (mode == MODE_ADD) && (ph_q == '0) && (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    pulse_d = run && ((last && !drop_now) || extra_now);
    if (load) begin
      cnt_d = '0;
      ph_d  = '0;
    end else if (run) begin
      if (last) begin
        cnt_d = '0;
        ph_d  = ph_wrap ? '0 : ph_q + ROT_W'(1);
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ph_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> !pulse_q); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    run |-> (cnt_q <= d_last)); // R3

  AST_NO_MIDCUT: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !last) |=> (cnt_q == DIV_W'($past(cnt_q) + DIV_W'(1)))); // R12

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && (mode != MODE_PLAIN)) |-> (ph_q <= divt)); // R5

  AST_ADD_SPLIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MODE_ADD) |-> (d_last != '0)); // R8

endmodule

// File: rtl/fcd_channel.sv
module fcd_channel
  import fcd_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             en_wr,
  input  logic             en_val,
  output logic [BUS_W-1:0] rd_data,
  output logic             clk_en_o,
  output logic             running_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  ctrl_t            act;
  logic             load;
  logic             at_bound;
  logic [DIV_W-1:0] d_last;
  logic [ROT_W-1:0] divt;
  rot_mode_e        mode;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fcd_ctrl_reg #(.BUS_W(BUS_W)) u_reg (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .en_wr    (en_wr),
    .en_val   (en_val),
    .at_bound (at_bound),
    .rd_data  (rd_data),
    .act_o    (act),
    .load_o   (load)
  );

  fcd_rot_decode u_dec (
    .cfg    (act),
    .d_last (d_last),
    .divt   (divt),
    .mode   (mode)
  );

  fcd_pulse_gen u_gen (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .run      (act.clk_on),
    .load     (load),
    .d_last   (d_last),
    .divt     (divt),
    .mode     (mode),
    .pulse_o  (clk_en_o),
    .at_bound (at_bound)
  );

  assign running_o = act.clk_on;

endmodule

// File: tb/fcd_channel_test.sv
module fcd_channel_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 32;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [BUS_W-1:0] wr_data;
  logic             en_wr;
  logic             en_val;
  logic [BUS_W-1:0] rd_data;
  logic             clk_en_o;
  logic             running_o;

  int checks = 0;
  int errors = 0;

  fcd_channel #(.BUS_W(BUS_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .rd_data   (rd_data),
    .clk_en_o  (clk_en_o),
    .running_o (running_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [BUS_W-1:0] mk(input bit en, input bit rot,
      input int sel, input bit fast, input int pre, input int dv);
    mk = '0;
    mk[15]    = en;
    mk[14]    = rot;
    mk[13:12] = sel[1:0];
    mk[11]    = fast;
    mk[10:8]  = pre[2:0];
    mk[7:0]   = dv[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [BUS_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_en(input bit v);
    @(negedge clk); en_wr = 1'b1; en_val = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic do_both(input logic [BUS_W-1:0] d, input bit v);
    @(negedge clk); wr_en = 1'b1; wr_data = d; en_wr = 1'b1; en_val = v;
    @(negedge clk); wr_en = 1'b0; en_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (clk_en_o) c++;
    end
  endtask

  task automatic rate_check(input string req, input int win, input int exp);
    int c;
    count_pulses(win, c);
    check(c == exp, req, c, exp);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!clk_en_o);
  endtask

  task automatic gap_to_next(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!clk_en_o);
  endtask

  task automatic t_reset();
    check(rd_data == '0, "R1 readback", rd_data, 0);
    check(clk_en_o == 1'b0, "R1 pulse", clk_en_o, 0);
    check(running_o == 1'b0, "R1 running", running_o, 0);
  endtask

  task automatic t_readback();
    do_write(32'hABCD_1234);
    check(rd_data == 32'h0000_1234, "R2 upper bits dropped", rd_data, 32'h1234);
    repeat (10) @(negedge clk);
    check(running_o == 1'b0, "R2 bit15 clear keeps idle", running_o, 0);
  endtask

  task automatic t_plain();
    int g;
    do_write(mk(1, 0, 0, 0, 0, 5));
    settle();
    check(running_o == 1'b1, "R3 running", running_o, 1);
    rate_check("R3 divide by 5", 100, 20);
    wait_pulse();
    gap_to_next(g);
    check(g == 5, "R3 gap", g, 5);
  endtask

  task automatic t_div_zero();
    do_write(mk(1, 0, 0, 0, 0, 0));
    settle();
    rate_check("R4 divider 0", 20, 20);
  endtask

  task automatic t_drop();
    do_write(mk(1, 1, 3, 0, 0, 2));
    settle();
    rate_check("R5 drop divt=4 D=2", 100, 40);
    do_write(mk(1, 1, 1, 0, 1, 1));
    settle();
    rate_check("R5 drop divt=32 D=1", 66, 64);
  endtask

  task automatic t_add();
    do_write(mk(1, 1, 3, 1, 0, 3));
    settle();
    rate_check("R6 add divt=4 D=3", 90, 40);
    do_write(mk(1, 1, 2, 1, 2, 2));
    settle();
    rate_check("R6 add divt=24 D=2", 92, 48);
  endtask

  task automatic t_sel_zero();
    do_write(mk(1, 1, 0, 0, 5, 3));
    settle();
    rate_check("R7 select 0", 30, 10);
  endtask

  task automatic t_add_div1();
    do_write(mk(1, 1, 3, 1, 0, 1));
    settle();
    rate_check("R8 add with D=1", 20, 20);
  endtask

  task automatic t_enable_only();
    logic [BUS_W-1:0] w;
    w = mk(1, 1, 2, 1, 2, 2);
    do_write(w);
    settle();
    do_en(1'b0);
    check(rd_data == (w & ~32'h8000), "R10 disable keeps fields", rd_data, w & ~32'h8000);
    settle();
    check(running_o == 1'b0, "R9 running low", running_o, 0);
    rate_check("R9 no pulses", 60, 0);
    do_en(1'b1);
    check(rd_data == w, "R10 enable keeps fields", rd_data, w);
    settle();
    rate_check("R10 rate restored", 92, 48);
  endtask

  task automatic t_both();
    do_both(mk(0, 0, 0, 0, 0, 4), 1'b1);
    check(rd_data == mk(1, 0, 0, 0, 0, 4), "R11 merge on", rd_data, mk(1, 0, 0, 0, 0, 4));
    settle();
    rate_check("R11 merged rate", 40, 10);
    do_both(mk(1, 0, 0, 0, 0, 6), 1'b0);
    check(rd_data == mk(0, 0, 0, 0, 0, 6), "R11 merge off", rd_data, mk(0, 0, 0, 0, 0, 6));
    settle();
    rate_check("R11 merged off no pulses", 30, 0);
  endtask

  task automatic t_resync();
    int t;
    int g;
    do_write(mk(1, 0, 0, 0, 0, 8));
    settle();
    wait_pulse();
    t = 0;
    do begin
      @(negedge clk);
      t++;
      if (t == 3) begin wr_en = 1'b1; wr_data = mk(1, 0, 0, 0, 0, 2); end
      else wr_en = 1'b0;
    end while (!clk_en_o);
    wr_en = 1'b0;
    check(t == 8, "R12 old period kept", t, 8);
    gap_to_next(g);
    check(g == 2, "R12 first new period", g, 2);
    gap_to_next(g);
    check(g == 2, "R12 second new period", g, 2);
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    en_wr   = 1'b0;
    en_val  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_plain();
    t_div_zero();
    t_drop();
    t_add();
    t_sel_zero();
    t_add_div1();
    t_enable_only();
    t_both();
    t_resync();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule